// File: doc/BRIEF.md
# Register-Transfer Control Sequencer

This block is the control unit of a 32-bit processor core that executes each instruction as a fixed sequence of numbered micro-steps. Every clock it drives a set of individual register-transfer strobes toward the datapath. The strobes cover the memory address register (MAR), the address translator (MMU), the memory data register (MDR), the instruction register (IR), the ALU operand latches, the register file and the program counter. The datapath holds the instruction register, and its contents come back on `instr`. The sequencer decodes that word in a dedicated cycle and branches to the matching micro-sequence.

Three sequences are built. The first is the common instruction fetch. The second is a load whose source address is the sum of two base/index registers inside the data segment. The third is an unconditional call that pushes the PC through the stack segment and jumps to the operand field. Any step that touches memory raises `mem_req` and stays put until `mem_ready` is high. Every other instruction word raises `illegal` for one cycle, and the sequencer then fetches again.

Top module: `rt_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the sequencer sits in the first fetch step and drives only `ctl[0]`.
- R2: Strobe map of `ctl`: bit 0 MAR takes code segment and PC; bit 1 MAR takes data segment and ALU result; bit 2 MAR takes stack segment and SP+1; bit 3 MAR passes to the MMU; bit 4 address bus driven; bit 5 MDR captures the data bus; bit 6 MDR takes the PC; bit 7 IR takes MDR; bit 8 ALU operand 1 from the register file; bit 9 ALU operand 2 from the register file; bit 10 ALU add; bit 11 flag update inhibited; bit 12 register file written from MDR; bit 13 PC loaded from the IR operand field; bit 14 PC incremented by one word.
- R2a: Fetch runs {bit 0}, then {bit 4 with a read request}, then {bit 5}, then {bit 7}. One decode cycle with `ctl` all zero follows.
- R3: In a memory step (fetch step 2, load step 5, call step 4), `mem_req` is high and every output holds its value until a cycle with `mem_ready` high. The step then advances at that clock edge.
- R4: The instruction word is split as follows: bit 31 is the privilege mode, bits 30:29 the class, bits 28:24 the opcode, bit 23 the operand count, bits 22:20 the addressing-mode pair, bits 19:15 ri, bits 14:10 rj and bits 9:5 rk. Class 00 with opcode 00001 and mode pair 110 (based-indexed source, register destination) is the based-indexed load.
- R5: The load runs seven steps: {8, sel=rj}, {9,10,11, sel=rk}, {1}, {3}, {4 with a read request}, {5}, {12,14, sel=ri}. `rf_sel` is zero in every other step.
- R6: Class 10 with opcode 00011 is the call. It runs five steps: {2}, {3}, {4}, {6 with a write request}, {13}.
- R7: Any other word raises `illegal` only in the decode cycle, with `ctl` zero, and the next step is fetch step 1.
- R8: The privilege-mode bit has no effect on decode or on any step.
- R9: The PC is incremented only in the last load step. The call loads the PC and never increments it. After the last step of either instruction, fetch step 1 follows.
- R10: `mem_we` is high only together with `mem_req` in the call's write step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Current instruction register contents from the datapath |
| mem_ready | input | 1 | Memory has completed the requested access |
| ctl | output | 15 | Register-transfer strobes, bit map in R2 |
| rf_sel | output | 5 | Register-file index used by the current step |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| illegal | output | 1 | Decode found no defined instruction |

## Verification
The bench sweeps every combination of class, opcode and addressing-mode pair, with the mode bit varying. This catches a decoder that matches only part of a field: such a decoder would start the load or call sequence for a word that should trap. Each memory step is held for zero, one and two wait cycles. A sequencer that ignored `mem_ready` would skip ahead, and one that dropped the request while waiting would show changed outputs. The register indices differ from instruction to instruction, so swapped ri/rj/rk slices show up on `rf_sel`. The closing step of each sequence is checked, which catches a PC increment leaking into the call or missing from the load.

// File: rtl/rts_pkg.sv
// Shared field positions, strobe indices, step and instruction-kind types
// for the register-transfer sequencer. Assumes a 32-bit instruction word
// laid out mode, class, opcode, count, addressing pair, operand fields.
package rts_pkg;

    localparam int INSTR_W = 32;
    localparam int CLS_W   = 2;
    localparam int OPC_W   = 5;
    localparam int AM_W    = 3;
    localparam int REG_W   = 5;

    localparam int CLS_LSB = INSTR_W - 1 - CLS_W;
    localparam int OPC_LSB = CLS_LSB - OPC_W;
    localparam int CNT_BIT = OPC_LSB - 1;
    localparam int AM_LSB  = CNT_BIT - AM_W;
    localparam int RI_LSB  = AM_LSB - REG_W;
    localparam int RJ_LSB  = RI_LSB - REG_W;
    localparam int RK_LSB  = RJ_LSB - REG_W;

    localparam logic [CLS_W-1:0] CLS_MOVE = 2'b00;
    localparam logic [CLS_W-1:0] CLS_CTRL = 2'b10;
    localparam logic [OPC_W-1:0] OPC_LDBI = 5'd1;
    localparam logic [OPC_W-1:0] OPC_CALL = 5'd3;
    localparam logic [AM_W-1:0]  AM_BI_TO_REG = 3'b110;

    // Strobe indices into the control vector
    localparam int C_MAR_CSPC  = 0;
    localparam int C_MAR_DSALU = 1;
    localparam int C_MAR_SSSP  = 2;
    localparam int C_MAR_MMU   = 3;
    localparam int C_ABUS      = 4;
    localparam int C_MDR_BUS   = 5;
    localparam int C_MDR_PC    = 6;
    localparam int C_IR_MDR    = 7;
    localparam int C_OP1_RF    = 8;
    localparam int C_OP2_RF    = 9;
    localparam int C_ALU_ADD   = 10;
    localparam int C_FLAG_INH  = 11;
    localparam int C_RF_MDR    = 12;
    localparam int C_PC_IR     = 13;
    localparam int C_PC_INC    = 14;
    localparam int CTL_W       = 15;

    typedef enum logic [4:0] {
        S_F1, S_F2, S_F3, S_F4, S_DEC,
        S_L1, S_L2, S_L3, S_L4, S_L5, S_L6, S_L7,
        S_C1, S_C2, S_C3, S_C4, S_C5
    } step_e;

    typedef enum logic [1:0] {
        K_ILL, K_LOAD, K_CALL
    } kind_e;

endpackage

// File: rtl/rts_decode.sv
// Instruction decoder: classifies the instruction word into a supported
// kind and slices the three register index fields. Purely combinational;
// assumes the word is stable while the sequencer is in decode or execute.
module rts_decode
    import rts_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output kind_e              kind,
    output logic [REG_W-1:0]   ri,
    output logic [REG_W-1:0]   rj,
    output logic [REG_W-1:0]   rk
);

    logic [CLS_W-1:0] cls;
    logic [OPC_W-1:0] opc;
    logic [AM_W-1:0]  am;
    logic             spare_unused;

    assign cls = instr[CLS_LSB +: CLS_W];
    assign opc = instr[OPC_LSB +: OPC_W];
    assign am  = instr[AM_LSB +: AM_W];
    assign ri  = instr[RI_LSB +: REG_W];
    assign rj  = instr[RJ_LSB +: REG_W];
    assign rk  = instr[RK_LSB +: REG_W];

    // mode bit, operand count and low operand bits do not steer the sequence
    assign spare_unused = ^{instr[INSTR_W-1], instr[CNT_BIT], instr[RK_LSB-1:0]};

    // Map class/opcode/addressing pair onto a sequence kind
    always_comb begin
        kind = K_ILL;
        if (cls == CLS_MOVE && opc == OPC_LDBI && am == AM_BI_TO_REG)
            kind = K_LOAD;
        else if (cls == CLS_CTRL && opc == OPC_CALL)
            kind = K_CALL;
    end

endmodule

// File: rtl/rts_fsm.sv
// Step counter of the sequencer: advances through the numbered micro-steps,
// branches at decode and holds memory steps until the ready input is high.
// Assumes the control table flags memory steps through mem_step.
module rts_fsm
    import rts_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  kind_e kind,
    input  logic  mem_step,
    input  logic  mem_ready,
    output step_e step,
    output logic  illegal
);

    step_e step_nxt;

    // Successor of each step, with the wait-state hold applied last
    always_comb begin
        case (step)
            S_F1:    step_nxt = S_F2;
            S_F2:    step_nxt = S_F3;
            S_F3:    step_nxt = S_F4;
            S_F4:    step_nxt = S_DEC;
            S_DEC: begin
                case (kind)
                    K_LOAD:  step_nxt = S_L1;
                    K_CALL:  step_nxt = S_C1;
                    default: step_nxt = S_F1;
                endcase
            end
            S_L1:    step_nxt = S_L2;
            S_L2:    step_nxt = S_L3;
            S_L3:    step_nxt = S_L4;
            S_L4:    step_nxt = S_L5;
            S_L5:    step_nxt = S_L6;
            S_L6:    step_nxt = S_L7;
            S_L7:    step_nxt = S_F1;
            S_C1:    step_nxt = S_C2;
            S_C2:    step_nxt = S_C3;
            S_C3:    step_nxt = S_C4;
            S_C4:    step_nxt = S_C5;
            S_C5:    step_nxt = S_F1;
            default: step_nxt = S_F1;
        endcase
        if (mem_step && !mem_ready)
            step_nxt = step;
    end

    // Step register with synchronous reset to the first fetch step
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= S_F1;
        else
            step <= step_nxt;
    end

    assign illegal = (step == S_DEC) && (kind == K_ILL);

endmodule

// File: rtl/rts_ctl_rom.sv
// Control table: converts the current step into register-transfer strobes,
// the register-file index and the memory request. Combinational; assumes
// register indices come from the decoder for the current instruction.
module rts_ctl_rom
    import rts_pkg::*;
(
    input  step_e             step,
    input  logic [REG_W-1:0]  ri,
    input  logic [REG_W-1:0]  rj,
    input  logic [REG_W-1:0]  rk,
    output logic [CTL_W-1:0]  ctl,
    output logic [REG_W-1:0]  rf_sel,
    output logic              mem_req,
    output logic              mem_we
);

    // One row per step: strobes, register index, request and direction
    always_comb begin
        ctl     = '0;
        rf_sel  = '0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        case (step)
            S_F1: ctl[C_MAR_CSPC] = 1'b1;
            S_F2: begin
                ctl[C_ABUS] = 1'b1;
                mem_req     = 1'b1;
            end
            S_F3: ctl[C_MDR_BUS] = 1'b1;
            S_F4: ctl[C_IR_MDR]  = 1'b1;
            S_L1: begin
                ctl[C_OP1_RF] = 1'b1;
                rf_sel        = rj;
            end
            S_L2: begin
                ctl[C_OP2_RF]  = 1'b1;
                ctl[C_ALU_ADD] = 1'b1;
                ctl[C_FLAG_INH] = 1'b1;
                rf_sel         = rk;
            end
            S_L3: ctl[C_MAR_DSALU] = 1'b1;
            S_L4: ctl[C_MAR_MMU]   = 1'b1;
            S_L5: begin
                ctl[C_ABUS] = 1'b1;
                mem_req     = 1'b1;
            end
            S_L6: ctl[C_MDR_BUS] = 1'b1;
            S_L7: begin
                ctl[C_RF_MDR] = 1'b1;
                ctl[C_PC_INC] = 1'b1;
                rf_sel        = ri;
            end
            S_C1: ctl[C_MAR_SSSP] = 1'b1;
            S_C2: ctl[C_MAR_MMU]  = 1'b1;
            S_C3: ctl[C_ABUS]     = 1'b1;
            S_C4: begin
                ctl[C_MDR_PC] = 1'b1;
                mem_req       = 1'b1;
                mem_we        = 1'b1;
            end
            S_C5: ctl[C_PC_IR] = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/rt_sequencer.sv
// Top of the register-transfer sequencer: decoder, step FSM and control
// table. Assumes the datapath presents the IR contents on instr from the
// decode cycle until the instruction's last step.
module rt_sequencer
    import rts_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               mem_ready,
    output logic [CTL_W-1:0]   ctl,
    output logic [REG_W-1:0]   rf_sel,
    output logic               mem_req,
    output logic               mem_we,
    output logic               illegal
);

    kind_e            kind;
    step_e            step;
    logic [REG_W-1:0] ri, rj, rk;

    rts_decode u_dec (
        .instr (instr),
        .kind  (kind),
        .ri    (ri),
        .rj    (rj),
        .rk    (rk)
    );

    rts_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .mem_step  (mem_req),
        .mem_ready (mem_ready),
        .step      (step),
        .illegal   (illegal)
    );

    rts_ctl_rom u_rom (
        .step    (step),
        .ri      (ri),
        .rj      (rj),
        .rk      (rk),
        .ctl     (ctl),
        .rf_sel  (rf_sel),
        .mem_req (mem_req),
        .mem_we  (mem_we)
    );

endmodule

// Protocol checker attached to every rt_sequencer instance.
module rt_sequencer_chk
    import rts_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mem_ready,
    input logic [CTL_W-1:0] ctl,
    input logic [REG_W-1:0] rf_sel,
    input logic             mem_req,
    input logic             mem_we,
    input logic             illegal
);

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(ctl) && $stable(rf_sel) && $stable(mem_we))); // R3

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[C_MAR_CSPC] |=> (ctl[C_ABUS] && mem_req && !mem_we)); // R2a

    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[C_IR_MDR] |=> (ctl == '0)); // R2a

    AST_TRAP_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (ctl[C_MAR_CSPC] && !illegal)); // R7

    AST_TRAP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (ctl == '0)); // R7

    AST_PC_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl[C_PC_INC] && ctl[C_PC_IR])); // R9

    AST_LAST_STEP_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[C_PC_INC] || ctl[C_PC_IR]) |=> ctl[C_MAR_CSPC]); // R9

    AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && ctl[C_MDR_PC])); // R10

    AST_MAR_SINGLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl[C_MAR_SSSP:C_MAR_CSPC])); // R2

endmodule

bind rt_sequencer rt_sequencer_chk u_chk (.*);

// File: tb/rt_sequencer_tb.sv
module rt_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        mem_ready = 1'b0;
    logic [14:0] ctl;
    logic [4:0]  rf_sel;
    logic        mem_req, mem_we, illegal;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rt_sequencer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .mem_ready (mem_ready),
        .ctl       (ctl),
        .rf_sel    (rf_sel),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .illegal   (illegal)
    );

    function automatic logic [14:0] bits(input int a, input int b = -1, input int c = -1);
        logic [14:0] v = '0;
        v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        return v;
    endfunction

    task automatic compare(input logic [14:0] ec, input logic [4:0] es, input logic er,
                           input logic ew, input logic ei, input string tag);
        n_chk++;
        if (ctl !== ec || rf_sel !== es || mem_req !== er || mem_we !== ew || illegal !== ei) begin
            n_fail++;
            $display("FAIL %s: ctl=%h sel=%0d req=%b we=%b ill=%b expected ctl=%h sel=%0d req=%b we=%b ill=%b",
                     tag, ctl, rf_sel, mem_req, mem_we, illegal, ec, es, er, ew, ei);
        end
    endtask

    // Check one step at the current negedge; memory steps wait nwait cycles first
    task automatic step(input logic [14:0] ec, input logic [4:0] es, input logic er,
                        input logic ew, input logic ei, input string tag, input int nwait);
        if (er) begin
            for (int w = 0; w < nwait; w++) begin
                mem_ready = 1'b0;
                compare(ec, es, er, ew, ei, {tag, " R3 wait"});
                @(posedge clk); @(negedge clk);
            end
            mem_ready = 1'b1;
        end
        compare(ec, es, er, ew, ei, tag);
        @(posedge clk); @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic run_instr(input logic [31:0] w, input int wf, input int wx);
        logic [1:0] c = w[30:29];
        logic [4:0] o = w[28:24];
        logic [2:0] a = w[22:20];
        logic [4:0] ri = w[19:15], rj = w[14:10], rk = w[9:5];
        instr = w;
        step(bits(0), 0, 0, 0, 0, "R2a F1", 0);
        step(bits(4), 0, 1, 0, 0, "R2a F2", wf);
        step(bits(5), 0, 0, 0, 0, "R2a F3", 0);
        step(bits(7), 0, 0, 0, 0, "R2a F4", 0);
        if (c == 2'b00 && o == 5'd1 && a == 3'b110) begin
            step('0, 0, 0, 0, 0, "R4 R8 decode load", 0);
            step(bits(8), rj, 0, 0, 0, "R5 L1", 0);
            step(bits(9, 10, 11), rk, 0, 0, 0, "R5 L2", 0);
            step(bits(1), 0, 0, 0, 0, "R5 L3", 0);
            step(bits(3), 0, 0, 0, 0, "R5 L4", 0);
            step(bits(4), 0, 1, 0, 0, "R5 L5", wx);
            step(bits(5), 0, 0, 0, 0, "R5 L6", 0);
            step(bits(12, 14), ri, 0, 0, 0, "R9 L7", 0);
        end else if (c == 2'b10 && o == 5'd3) begin
            step('0, 0, 0, 0, 0, "R6 R8 decode call", 0);
            step(bits(2), 0, 0, 0, 0, "R6 C1", 0);
            step(bits(3), 0, 0, 0, 0, "R6 C2", 0);
            step(bits(4), 0, 0, 0, 0, "R6 C3", 0);
            step(bits(6), 0, 1, 1, 0, "R10 C4", wx);
            step(bits(13), 0, 0, 0, 0, "R9 C5", 0);
        end else begin
            step('0, 0, 0, 0, 1, "R7 R8 decode trap", 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare(bits(0), 0, 0, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        compare(bits(0), 0, 0, 0, 0, "R1 after reset");
        // directed: both supported kinds under both privilege modes
        for (int m = 0; m < 2; m++) begin
            run_instr({m[0], 2'b00, 5'd1, 1'b1, 3'b110, 5'd17, 5'd4, 5'd30, 5'd0}, 2, 1);
            run_instr({m[0], 2'b10, 5'd3, 1'b0, 3'b000, 20'hABCDE}, 0, 2);
        end
        // sweep of class, opcode and addressing pair
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 32; o++)
                for (int a = 0; a < 8; a++) begin
                    int idx = c * 256 + o * 8 + a;
                    logic [4:0] ri = 5'((o * 7 + a) % 32);
                    logic [4:0] rj = 5'((o + 3 * a + c) % 32);
                    logic [4:0] rk = 5'((31 - o + a) % 32);
                    run_instr({1'(idx ^ (idx >> 3)), 2'(c), 5'(o), 1'(a), 3'(a), ri, rj, rk, 5'(idx)},
                              idx % 3, (idx / 3) % 3);
                end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule